// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Slice

This block is a pipelined arithmetic slice for filters and other signal-processing datapaths. Two 18-bit signed operands can first pass through a pre-adder that forms their sum or difference. An 18x18 signed multiplier then takes the result and a third operand. A 48-bit post-adder combines two selected operands, X and Z, and can run as an adder, a subtracter or an accumulator. Per-cycle control comes from an 8-bit operation word that drives the pre-adder, the operand selectors and the post-adder direction.

A 48-bit cascade input and a matching cascade output let neighbouring slices be chained into wide sums or systolic filter taps. The carry into the post-adder comes either from a bit of the operation word or from an external carry pin, chosen by a static parameter. Every input port has its own register depth, set by parameters. The result register and the carry-out register are always present.

Top module: `mac_preadd_slice`

## Requirements
- R1: A synchronous active-high reset clears every pipeline register, so that p_out, pcout, prod_out and carry_out all read zero while reset is held.
- R2: When opmode[4]=1, the multiplier's second operand is d_in+b_in (opmode[6]=0) or d_in-b_in (opmode[6]=1), wrapped to 18 bits. When opmode[4]=0, b_in is passed straight to the multiplier.
- R3: The multiplier forms the signed 36-bit product of a_in and its second operand and presents it on prod_out, including the case -131072 x -131072 = 2^34.
- R4: The X operand is selected by opmode[1:0]: 00 gives zero, 01 gives the product sign-extended to 48 bits, 10 gives the current result register, and 11 gives {d_in[11:0], a_in, multiplier second operand}.
- R5: The Z operand is selected by opmode[3:2]: 00 gives zero, 01 gives pcin, 10 gives the current result register, and 11 gives c_in.
- R6: The post-adder computes Z+(X+cin) when opmode[7]=0 and Z-(X+cin) when opmode[7]=1, both in 49 bits. p_out takes bits 47:0 and carry_out takes bit 48, which is the carry for an add and the borrow for a subtract.
- R7: With the default carry-source parameter (0), cin is opmode[5] and the carry_in pin has no effect on any output.
- R8: With X set to the product and Z set to the result register, p_out grows by the sign-extended product plus cin on every cycle, or shrinks by that amount when opmode[7]=1.
- R9: pcout always carries the same value as p_out.
- R10: With the default register depths, a change on a_in reaches prod_out after exactly 3 clock edges and p_out after exactly 4.
- R11: With the default register depths, a change on c_in reaches p_out after exactly 2 clock edges, and a change on pcin after exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Signed multiplier operand |
| b_in | input | 18 | Signed operand to the pre-adder or multiplier |
| d_in | input | 18 | Signed pre-adder operand |
| c_in | input | 48 | General post-adder operand |
| pcin | input | 48 | Cascade input from the neighbouring slice |
| carry_in | input | 1 | External carry, used when the carry-source parameter is 1 |
| opmode | input | 8 | Operation word |
| p_out | output | 48 | Registered result |
| pcout | output | 48 | Cascade copy of the result |
| prod_out | output | 36 | Raw signed product |
| carry_out | output | 1 | Bit 48 of the post-adder result, registered |

## Verification
The hardest case to reach is accumulation, where the result feeds back through the Z selector. Its value depends on every earlier cycle and on how the operation word's register lines up with the longer product path. The stimulus therefore holds operands and the operation word steady until the pipeline settles, then checks each new p_out against the previous sample plus the product and carry, in both add and subtract directions. Each latency requirement is checked by changing a single input on a settled pipeline and sampling the output on the cycles on either side of the expected edge.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  // positions inside the 7-bit staged control word (opmode minus bit 5)
  localparam int CW_POST_SUB = 6;
  localparam int CW_PRE_SUB  = 5;
  localparam int CW_USE_PRE  = 4;

  typedef enum logic [1:0] {
    XS_ZERO = 2'b00,
    XS_PROD = 2'b01,
    XS_PREG = 2'b10,
    XS_CAT  = 2'b11
  } xsel_e;

  typedef enum logic [1:0] {
    ZS_ZERO = 2'b00,
    ZS_CASC = 2'b01,
    ZS_PREG = 2'b10,
    ZS_CIN  = 2'b11
  } zsel_e;
endpackage

// File: rtl/mac_delay.sv
module mac_delay #(
  parameter int W     = 18,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/mac_premul.sv
module mac_premul #(
  parameter int DW     = 18,
  parameter int B1_REG = 1,
  parameter int M_REG  = 1,
  localparam int MW    = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_op,
  input  logic [DW-1:0] b_pre,
  input  logic [DW-1:0] d_pre,
  input  logic          pre_sub,
  input  logic          use_pre,
  output logic [DW-1:0] b_mul,
  output logic [MW-1:0] m_q
);
  logic [DW-1:0]        pre_sum;
  logic [DW-1:0]        b_sel;
  logic signed [MW-1:0] mul;

  // pre-adder wraps to the operand width
  assign pre_sum = pre_sub ? (d_pre - b_pre) : (d_pre + b_pre);
  assign b_sel   = use_pre ? pre_sum : b_pre;

  mac_delay #(.W(DW), .DEPTH(B1_REG)) u_b1 (
    .clk(clk), .rst(rst), .d(b_sel), .q(b_mul)
  );

  assign mul = $signed(a_op) * $signed(b_mul);

  mac_delay #(.W(MW), .DEPTH(M_REG)) u_m (
    .clk(clk), .rst(rst), .d(mul), .q(m_q)
  );

  generate
    if (M_REG == 1) begin : g_mchk
      // R3: registered product equals the signed product of the operands one cycle back
      assert_mul_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($signed(m_q) == $signed($past(a_op)) * $signed($past(b_mul))));
    end
  endgenerate
endmodule

// File: rtl/mac_postadd.sv
module mac_postadd
  import mac_slice_pkg::*;
#(
  parameter int PW = 48,
  parameter int MW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    x_sel,
  input  logic [1:0]    z_sel,
  input  logic          sub,
  input  logic          cin,
  input  logic [MW-1:0] prod,
  input  logic [PW-1:0] cat_op,
  input  logic [PW-1:0] casc,
  input  logic [PW-1:0] c_op,
  output logic [PW-1:0] p_q,
  output logic          co_q
);
  logic [PW-1:0] x_op, z_op;
  logic [PW:0]   x_plus, sum;

  always_comb begin
    case (xsel_e'(x_sel))
      XS_PROD: x_op = {{(PW-MW){prod[MW-1]}}, prod};
      XS_PREG: x_op = p_q;
      XS_CAT:  x_op = cat_op;
      default: x_op = '0;
    endcase
    case (zsel_e'(z_sel))
      ZS_CASC: z_op = casc;
      ZS_PREG: z_op = p_q;
      ZS_CIN:  z_op = c_op;
      default: z_op = '0;
    endcase
  end

  assign x_plus = {1'b0, x_op} + {{PW{1'b0}}, cin};
  assign sum    = sub ? ({1'b0, z_op} - x_plus) : ({1'b0, z_op} + x_plus);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q  <= '0;
      co_q <= 1'b0;
    end else begin
      p_q  <= sum[PW-1:0];
      co_q <= sum[PW];
    end
  end

  // R1: one cycle after reset the result and carry read zero
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (p_q == '0 && !co_q));

  // R6: with both operands zero and an add, the result is just the carry-in
  assert_zero_sum_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x_sel == 2'b00 && z_sel == 2'b00 && !sub))
      |-> (p_q == {{(PW-1){1'b0}}, $past(cin)} && !co_q));

  // R8: accumulating zero with no carry leaves the result unchanged
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x_sel == 2'b00 && z_sel == 2'b10 && !cin))
      |-> ($stable(p_q) && !co_q));
endmodule

// File: rtl/mac_preadd_slice.sv
module mac_preadd_slice
  import mac_slice_pkg::*;
#(
  parameter int DW              = 18,
  parameter int PW              = 48,
  parameter int A_STAGES        = 2,
  parameter int B0_REG          = 1,
  parameter int B1_REG          = 1,
  parameter int D_REG           = 1,
  parameter int C_REG           = 1,
  parameter int OP_REG          = 1,
  parameter int CIN_REG         = 1,
  parameter int M_REG           = 1,
  parameter int CARRY_FROM_PORT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] d_in,
  input  logic [PW-1:0] c_in,
  input  logic [PW-1:0] pcin,
  input  logic          carry_in,
  input  logic [7:0]    opmode,
  output logic [PW-1:0] p_out,
  output logic [PW-1:0] pcout,
  output logic [2*DW-1:0] prod_out,
  output logic          carry_out
);
  localparam int MW   = 2 * DW;
  localparam int CATD = PW - 2 * DW;

  logic [DW-1:0] a_q, b_q, d_q, b_mul;
  logic [PW-1:0] c_q, p_q;
  logic [6:0]    ctl_d, ctl_q;
  logic          cin_src, cin_q, co_q;
  logic [MW-1:0] m_q;

  // control word without the carry bit, which has its own path
  assign ctl_d   = {opmode[7:6], opmode[4:0]};
  assign cin_src = (CARRY_FROM_PORT != 0) ? carry_in : opmode[5];

  mac_delay #(.W(DW), .DEPTH(A_STAGES)) u_a  (.clk(clk), .rst(rst), .d(a_in),    .q(a_q));
  mac_delay #(.W(DW), .DEPTH(B0_REG))   u_b0 (.clk(clk), .rst(rst), .d(b_in),    .q(b_q));
  mac_delay #(.W(DW), .DEPTH(D_REG))    u_d  (.clk(clk), .rst(rst), .d(d_in),    .q(d_q));
  mac_delay #(.W(PW), .DEPTH(C_REG))    u_c  (.clk(clk), .rst(rst), .d(c_in),    .q(c_q));
  mac_delay #(.W(7),  .DEPTH(OP_REG))   u_op (.clk(clk), .rst(rst), .d(ctl_d),   .q(ctl_q));
  mac_delay #(.W(1),  .DEPTH(CIN_REG))  u_ci (.clk(clk), .rst(rst), .d(cin_src), .q(cin_q));

  mac_premul #(.DW(DW), .B1_REG(B1_REG), .M_REG(M_REG)) u_premul (
    .clk     (clk),
    .rst     (rst),
    .a_op    (a_q),
    .b_pre   (b_q),
    .d_pre   (d_q),
    .pre_sub (ctl_q[CW_PRE_SUB]),
    .use_pre (ctl_q[CW_USE_PRE]),
    .b_mul   (b_mul),
    .m_q     (m_q)
  );

  mac_postadd #(.PW(PW), .MW(MW)) u_post (
    .clk    (clk),
    .rst    (rst),
    .x_sel  (ctl_q[1:0]),
    .z_sel  (ctl_q[3:2]),
    .sub    (ctl_q[CW_POST_SUB]),
    .cin    (cin_q),
    .prod   (m_q),
    .cat_op ({d_q[CATD-1:0], a_q, b_mul}),
    .casc   (pcin),
    .c_op   (c_q),
    .p_q    (p_q),
    .co_q   (co_q)
  );

  assign p_out     = p_q;
  assign pcout     = p_q;
  assign prod_out  = m_q;
  assign carry_out = co_q;
endmodule

// File: tb/mac_preadd_slice_tb.sv
`timescale 1ns/1ps
module mac_preadd_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] a_in = '0, b_in = '0, d_in = '0;
  logic [47:0] c_in = '0, pcin = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  opmode = '0;
  logic [47:0] p_out, pcout;
  logic [35:0] prod_out;
  logic        carry_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mac_preadd_slice dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .d_in(d_in),
    .c_in(c_in), .pcin(pcin), .carry_in(carry_in), .opmode(opmode),
    .p_out(p_out), .pcout(pcout), .prod_out(prod_out), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] f_bop(input logic [7:0] op, input logic [17:0] b, input logic [17:0] d);
    if (!op[4]) return b;
    return op[6] ? (d - b) : (d + b);
  endfunction

  function automatic logic [35:0] f_prod(input logic [17:0] a, input logic [17:0] bop);
    logic signed [35:0] r;
    r = $signed(a) * $signed(bop);
    return r;
  endfunction

  function automatic logic [48:0] f_post(input logic [7:0] op, input logic [47:0] x, input logic [47:0] z);
    logic [48:0] xp;
    xp = {1'b0, x} + {48'b0, op[5]};
    return op[7] ? ({1'b0, z} - xp) : ({1'b0, z} + xp);
  endfunction

  function automatic logic [47:0] sext(input logic [35:0] p);
    return {{12{p[35]}}, p};
  endfunction

  // settled result for operation words that select neither operand as the result register
  task automatic run_steady(input string req, input logic [7:0] op, input logic [17:0] a,
                            input logic [17:0] b, input logic [17:0] d,
                            input logic [47:0] c, input logic [47:0] pc);
    logic [17:0] bop;
    logic [35:0] pr;
    logic [47:0] x, z;
    logic [48:0] s;
    opmode = op; a_in = a; b_in = b; d_in = d; c_in = c; pcin = pc;
    repeat (6) @(negedge clk);
    bop = f_bop(op, b, d);
    pr  = f_prod(a, bop);
    case (op[1:0])
      2'b01:   x = sext(pr);
      2'b11:   x = {d[11:0], a, bop};
      default: x = '0;
    endcase
    case (op[3:2])
      2'b01:   z = pc;
      2'b11:   z = c;
      default: z = '0;
    endcase
    s = f_post(op, x, z);
    check({req, " p_out"}, p_out, s[47:0]);
    check({req, " carry_out"}, carry_out, s[48]);
    check({req, " prod_out"}, prod_out, pr);
    check("R9 pcout", pcout, p_out);
  endtask

  task automatic run_accum(input string req, input logic [7:0] op, input logic [17:0] a, input logic [17:0] b);
    logic [47:0] prev;
    logic [48:0] s;
    logic [35:0] pr;
    opmode = op; a_in = a; b_in = b; d_in = '0;
    repeat (6) @(negedge clk);
    pr = f_prod(a, b);
    for (int k = 0; k < 6; k++) begin
      prev = p_out;
      @(negedge clk);
      s = f_post(op, sext(pr), prev);
      check({req, " accumulate"}, p_out, s[47:0]);
      check({req, " accumulate carry"}, carry_out, s[48]);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with busy inputs
    a_in = 18'h1234; b_in = 18'h0777; c_in = 48'hFFFF; opmode = 8'b0011_1101;
    repeat (4) @(negedge clk);
    check("R1 p_out reset", p_out, 48'h0);
    check("R1 pcout reset", pcout, 48'h0);
    check("R1 prod_out reset", prod_out, 36'h0);
    check("R1 carry_out reset", carry_out, 1'b0);
    rst = 1'b0;

    // R2 pre-adder add, subtract, wrap, bypass
    run_steady("R2 preadd add", 8'b0001_0001, 18'd3, 18'd5, 18'd7, 48'd0, 48'd0);
    run_steady("R2 preadd sub", 8'b0101_0001, 18'h3FFFE, 18'd9, 18'd4, 48'd0, 48'd0);
    run_steady("R2 preadd wrap", 8'b0001_0001, 18'd2, 18'd1, 18'h1FFFF, 48'd0, 48'd0);
    run_steady("R2 bypass", 8'b0100_0001, 18'd11, 18'd13, 18'd100, 48'd0, 48'd0);
    // R3 most negative squared
    run_steady("R3 max neg", 8'b0000_0001, 18'h20000, 18'h20000, 18'd0, 48'd0, 48'd0);
    check("R3 2^34", prod_out, 36'h4_0000_0000);
    // R4 concatenation, R5 selections
    run_steady("R4 concat", 8'b0000_0011, 18'h2AAAA, 18'h15555, 18'hABC, 48'd0, 48'd0);
    run_steady("R5 Z=C", 8'b0000_1100, 18'd0, 18'd0, 18'd0, 48'h1234_5678_9ABC, 48'd0);
    run_steady("R5 Z=pcin", 8'b0000_0101, 18'd3, 18'd4, 18'd0, 48'd0, 48'h0000_0000_1000);
    // R6 carry out and borrow
    run_steady("R6 carry", 8'b0010_1100, 18'd0, 18'd0, 18'd0, 48'hFFFF_FFFF_FFFF, 48'd0);
    check("R6 carry value", {carry_out, p_out}, 49'h1_0000_0000_0000);
    run_steady("R6 borrow", 8'b1000_0001, 18'd5, 18'd1, 18'd0, 48'd0, 48'd0);
    check("R6 borrow value", carry_out, 1'b1);
    // R7 carry_in pin has no effect
    carry_in = 1'b1;
    run_steady("R7 pin ignored", 8'b0000_1100, 18'd0, 18'd0, 18'd0, 48'd100, 48'd0);
    check("R7 pin ignored value", p_out, 48'd100);
    carry_in = 1'b0;

    // R8 accumulation, add and subtract
    run_accum("R8 add", 8'b0000_1001, 18'd3, 18'h3FFF9);
    run_accum("R8 sub", 8'b1010_1001, 18'd1000, 18'd77);
    opmode = 8'b0000_1000;
    repeat (3) @(negedge clk);
    begin
      logic [47:0] held;
      held = p_out;
      repeat (2) @(negedge clk);
      check("R8 zero accumulate holds", p_out, held);
    end

    // R10 product path latency
    run_steady("R10 settle", 8'b0000_0001, 18'd2, 18'd3, 18'd0, 48'd0, 48'd0);
    a_in = 18'd5;
    @(negedge clk);
    @(negedge clk);
    check("R10 prod_out before edge 3", prod_out, 36'd6);
    @(negedge clk);
    check("R10 prod_out at edge 3", prod_out, 36'd15);
    check("R10 p_out before edge 4", p_out, 48'd6);
    @(negedge clk);
    check("R10 p_out at edge 4", p_out, 48'd15);

    // R11 C and cascade latency
    run_steady("R11 settle C", 8'b0000_1100, 18'd0, 18'd0, 18'd0, 48'd10, 48'd0);
    c_in = 48'd77;
    @(negedge clk);
    check("R11 C before edge 2", p_out, 48'd10);
    @(negedge clk);
    check("R11 C at edge 2", p_out, 48'd77);
    run_steady("R11 settle pcin", 8'b0000_0100, 18'd0, 18'd0, 18'd0, 48'd0, 48'd5);
    pcin = 48'd9;
    @(negedge clk);
    check("R11 pcin at edge 1", p_out, 48'd9);

    // random mix of non-feedback operations (R2 R3 R4 R5 R6 R7 R9)
    for (int it = 0; it < 60; it++) begin
      logic [7:0] op;
      logic [1:0] xs, zs;
      xs = 2'($urandom % 3); if (xs == 2'd2) xs = 2'd3;
      zs = 2'($urandom % 3); if (zs == 2'd2) zs = 2'd3;
      op = {4'($urandom), zs, xs};
      carry_in = 1'($urandom);
      run_steady("R4 R5 R6 random", op, 18'($urandom), 18'($urandom), 18'($urandom),
                 {16'($urandom), 32'($urandom)}, {16'($urandom), 32'($urandom)});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule